// File: doc/BRIEF.md
# Prescaled 64-bit Alarm Timer

This block is one general-purpose timer channel reached through a plain word-addressed register port. A 64-bit counter steps up or down once per programmable number of clocks. A 16-bit prescaler sets that step rate. Software can overwrite the counter from a 64-bit preset with a strobe. It reads the counter through a snapshot that an explicit strobe captures, so the two 32-bit halves always agree.

A 64-bit compare value, once armed, raises an alarm when the counter equals it. The alarm disarms itself at that point, and can optionally copy the preset back into the counter. Each alarm sets a sticky status bit. A mask gates that bit, and writing a one clears it. The status drives two outputs: a level interrupt and a one-cycle edge interrupt.

Register words, selected by `wr_addr` and `rd_addr`:

| Word | Meaning |
|------|---------|
| 0 | control |
| 1 / 2 | snapshot low / high |
| 3 | snapshot strobe |
| 4 / 5 | preset low / high |
| 6 | preset strobe |
| 7 / 8 | compare low / high |
| 9 | mask |
| 10 | raw status |
| 11 | masked status |
| 12 | clear |

Control fields:

| Bits | Field |
|------|-------|
| 0 | run |
| 1 | up (1 counts up) |
| 2 | auto-preset |
| 3 | arm |
| 4 | level-irq enable |
| 5 | edge-irq enable |
| 31:16 | divider |

Reserved control bits read back as zero.

Top module: `alarm_tmr`

## Requirements
- R1: After reset every register reads zero, the counter holds 0 and stays paused, and both interrupt outputs are low.
- R2: While run is 1 the counter steps once every `divider` clocks. A divider of 1 steps every clock, and a divider of 0 means 65536 clocks.
- R3: With run at 0 the counter keeps its value.
- R4: With up=1 the counter increments, and with up=0 it decrements. Both directions wrap modulo 2^64.
- R5: A write to word 6 copies the 64-bit preset (words 4 and 5) into the counter at that clock edge, whatever the run state.
- R6: A write to word 3 captures the live 64-bit counter into words 1 and 2. Those words keep that value while the counter moves on, including a carry between the halves.
- R7: When arm is 1 and the counter equals the compare value (words 7 and 8), the alarm fires and sets bit 0 of the raw status (word 10) on the next edge.
- R8: A firing clears the arm bit (control bit 3). No new alarm happens until software writes arm to 1 again.
- R9: With auto-preset set, a firing loads the preset into the counter on the next edge, and counting continues from there.
- R10: Word 11 bit 0 reads raw status AND mask (word 9 bit 0). Writing 1 to bit 0 of word 12 clears the raw status.
- R11: `irq_level` is high exactly while the masked status and the level-irq enable are both 1.
- R12: `irq_edge` is a one-cycle pulse in the cycle after a firing when the edge-irq enable is 1. It stays low when that enable is 0.
- R13: Any write to the control word restarts the prescaler phase at zero, so the next step comes a full divider period after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | write strobe for one word |
| wr_addr | input | 4 | word written |
| wr_data | input | 32 | write data |
| rd_addr | input | 4 | word read (combinational) |
| rd_data | output | 32 | read data |
| irq_level | output | 1 | level interrupt |
| irq_edge | output | 1 | single-cycle edge interrupt |

## Verification
The assertions check the following on every cycle:
- the counter's step direction and the value it holds while paused;
- that the preset copy and the auto-preset land on the following edge;
- that a firing disarms the compare and sets the raw status;
- that the edge interrupt never lasts two cycles;
- that a clear always drops the level interrupt.

Other behaviour only the directed scenarios can show:
- the exact step rate of each divider, including the 65536 case;
- the prescaler restart on a control write;
- snapshot coherence across the 32-bit carry;
- the mask view of the status and the absence of a second alarm before re-arming.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int DATA_W = 32;
    localparam int DIV_W  = 16;
    localparam int ADDR_W = 4;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int RSVD_W = DATA_W - DIV_W - 6;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL     = 4'd0,
        A_SNAP_LO  = 4'd1,
        A_SNAP_HI  = 4'd2,
        A_SNAP_GO  = 4'd3,
        A_PRE_LO   = 4'd4,
        A_PRE_HI   = 4'd5,
        A_PRE_GO   = 4'd6,
        A_CMP_LO   = 4'd7,
        A_CMP_HI   = 4'd8,
        A_IRQ_MASK = 4'd9,
        A_IRQ_RAW  = 4'd10,
        A_IRQ_STAT = 4'd11,
        A_IRQ_CLR  = 4'd12
    } reg_addr_e;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [RSVD_W-1:0] rsvd;
        logic              edge_ie;
        logic              lvl_ie;
        logic              arm;
        logic              autopre;
        logic              up;
        logic              run;
    } ctrl_t;

    // Last phase value before a step; divider 0 wraps to 65535 (= 65536 clocks).
    function automatic logic [DIV_W-1:0] phase_last(input logic [DIV_W-1:0] d);
        return d - DIV_W'(1);
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] last;

    assign last = phase_last(div);
    assign tick = run & ~restart & (phase_q == last);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= tick ? '0 : phase_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             up,
    input  logic             pre_go,
    input  logic [CNT_W-1:0] pre_val,
    input  logic             arm,
    input  logic             autopre,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             fire
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt  = cnt_q;
    assign fire = arm & (cnt_q == cmp_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (pre_go || (fire && autopre)) begin
            cnt_q <= pre_val;
        end else if (tick) begin
            cnt_q <= up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/alarm_tmr.sv
`timescale 1ns/1ps
module alarm_tmr
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_level,
    output logic              irq_edge
);
    localparam int HALVES = CNT_W / DATA_W;

    ctrl_t            ctrl_q, ctrl_wdat;
    logic [CNT_W-1:0] pre_q, cmp_q, snap_q, cnt;
    logic             mask_q, raw_q, edge_q;
    logic             ctrl_wr, snap_go, pre_go, clr_hit, tick, fire;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign snap_go = wr_en && (wr_addr == A_SNAP_GO);
    assign pre_go  = wr_en && (wr_addr == A_PRE_GO);
    assign clr_hit = wr_en && (wr_addr == A_IRQ_CLR) && wr_data[0];

    always_comb begin
        ctrl_wdat      = ctrl_t'(wr_data);
        ctrl_wdat.rsvd = '0;
    end

    // Preset and compare words: one register slice per 32-bit half.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                pre_q[h*DATA_W +: DATA_W] <= '0;
                cmp_q[h*DATA_W +: DATA_W] <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADDR_W'(int'(A_PRE_LO) + h))
                    pre_q[h*DATA_W +: DATA_W] <= wr_data;
                if (wr_addr == ADDR_W'(int'(A_CMP_LO) + h))
                    cmp_q[h*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= 1'b0;
            raw_q  <= 1'b0;
            edge_q <= 1'b0;
            snap_q <= '0;
        end else begin
            if (ctrl_wr)   ctrl_q     <= ctrl_wdat;
            else if (fire) ctrl_q.arm <= 1'b0;
            if (wr_en && wr_addr == A_IRQ_MASK) mask_q <= wr_data[0];
            if (fire)         raw_q <= 1'b1;
            else if (clr_hit) raw_q <= 1'b0;
            edge_q <= fire & ctrl_q.edge_ie;
            if (snap_go) snap_q <= cnt;
        end
    end

    assign irq_level = raw_q & mask_q & ctrl_q.lvl_ie;
    assign irq_edge  = edge_q;

    tmr_prescaler u_psc (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .restart (ctrl_wr),
        .div     (ctrl_q.div),
        .tick    (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .up      (ctrl_q.up),
        .pre_go  (pre_go),
        .pre_val (pre_q),
        .arm     (ctrl_q.arm),
        .autopre (ctrl_q.autopre),
        .cmp_val (cmp_q),
        .cnt     (cnt),
        .fire    (fire)
    );

    always_comb begin
        case (rd_addr)
            A_CTRL:     rd_data = ctrl_q;
            A_SNAP_LO:  rd_data = snap_q[DATA_W-1:0];
            A_SNAP_HI:  rd_data = snap_q[CNT_W-1:DATA_W];
            A_PRE_LO:   rd_data = pre_q[DATA_W-1:0];
            A_PRE_HI:   rd_data = pre_q[CNT_W-1:DATA_W];
            A_CMP_LO:   rd_data = cmp_q[DATA_W-1:0];
            A_CMP_HI:   rd_data = cmp_q[CNT_W-1:DATA_W];
            A_IRQ_MASK: rd_data = {{(DATA_W-1){1'b0}}, mask_q};
            A_IRQ_RAW:  rd_data = {{(DATA_W-1){1'b0}}, raw_q};
            A_IRQ_STAT: rd_data = {{(DATA_W-1){1'b0}}, raw_q & mask_q};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
    parameter int CNT_W = tmr_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             up,
    input logic             autopre,
    input logic             arm,
    input logic             tick,
    input logic             fire,
    input logic             pre_go,
    input logic             ctrl_wr,
    input logic             clr_hit,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] pre_val,
    input logic             raw,
    input logic             irq_level,
    input logic             irq_edge
);
    a_r3_pause_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !pre_go && !(fire && autopre)) |=> (cnt == $past(cnt)));

    a_r4_up_step: assert property (@(posedge clk) disable iff (rst)
        (tick && up && !pre_go && !(fire && autopre)) |=> (cnt == $past(cnt) + 1'b1));

    a_r4_down_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !up && !pre_go && !(fire && autopre)) |=> (cnt == $past(cnt) - 1'b1));

    a_r5_preset_copy: assert property (@(posedge clk) disable iff (rst)
        pre_go |=> (cnt == $past(pre_val)));

    a_r9_auto_preset: assert property (@(posedge clk) disable iff (rst)
        (fire && autopre) |=> (cnt == $past(pre_val)));

    a_r8_disarm: assert property (@(posedge clk) disable iff (rst)
        (fire && !ctrl_wr) |=> !arm);

    a_r7_raw_set: assert property (@(posedge clk) disable iff (rst)
        fire |=> raw);

    a_r12_one_cycle: assert property (@(posedge clk) disable iff (rst)
        irq_edge |=> !irq_edge);

    a_r12_after_fire: assert property (@(posedge clk) disable iff (rst)
        irq_edge |-> $past(fire));

    a_r11_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && !fire) |=> !irq_level);
endmodule

bind alarm_tmr tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (ctrl_q.run),
    .up        (ctrl_q.up),
    .autopre   (ctrl_q.autopre),
    .arm       (ctrl_q.arm),
    .tick      (tick),
    .fire      (fire),
    .pre_go    (pre_go),
    .ctrl_wr   (ctrl_wr),
    .clr_hit   (clr_hit),
    .cnt       (cnt),
    .pre_val   (pre_q),
    .raw       (raw_q),
    .irq_level (irq_level),
    .irq_edge  (irq_edge)
);

// File: tb/tb_alarm_tmr.sv
`timescale 1ns/1ps
module tb_alarm_tmr;
    localparam logic [3:0] W_CTRL = 4'd0, W_SLO = 4'd1, W_SHI = 4'd2, W_SGO = 4'd3,
                           W_PLO = 4'd4, W_PHI = 4'd5, W_PGO = 4'd6, W_CLO = 4'd7,
                           W_CHI = 4'd8, W_MASK = 4'd9, W_RAW = 4'd10, W_STAT = 4'd11,
                           W_CLR = 4'd12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_level, irq_edge;

    int n_chk = 0;
    int n_bad = 0;
    int edge_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    alarm_tmr dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_level(irq_level), .irq_edge(irq_edge)
    );

    always @(negedge clk) if (!rst && irq_edge) edge_cnt++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkctrl(input logic [15:0] div, input bit edge_ie,
        input bit lvl_ie, input bit arm, input bit autopre, input bit up, input bit run);
        return {div, 10'b0, edge_ie, lvl_ie, arm, autopre, up, run};
    endfunction

    // Called at a negedge; the write lands on the next posedge; returns at the following negedge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1 v = rd_data;
        @(negedge clk);
    endtask

    task automatic snap(output logic [63:0] v);
        logic [31:0] lo, hi;
        wr(W_SGO, 32'd0);
        rd(W_SLO, lo);
        rd(W_SHI, hi);
        v = {hi, lo};
    endtask

    task automatic setcnt(input logic [63:0] v);
        wr(W_PLO, v[31:0]);
        wr(W_PHI, v[63:32]);
        wr(W_PGO, 32'd0);
    endtask

    // Run for k clock edges after the control write, then pause with the same settings.
    task automatic run_for(input logic [31:0] c, input int k);
        wr(W_CTRL, c);
        repeat (k) @(negedge clk);
        wr(W_CTRL, c & ~32'h9);
    endtask

    task automatic t_reset;
        logic [31:0] v; logic [63:0] s;
        chk("R1 irq_level", irq_level, 0);
        chk("R1 irq_edge", irq_edge, 0);
        rd(W_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(W_MASK, v);  chk("R1 mask", v, 0);
        rd(W_RAW, v);   chk("R1 raw", v, 0);
        rd(W_PHI, v);   chk("R1 preset", v, 0);
        rd(W_CHI, v);   chk("R1 compare", v, 0);
        repeat (10) @(negedge clk);
        snap(s);        chk("R1 counter paused at 0", s, 0);
    endtask

    task automatic t_preset;
        logic [63:0] s;
        setcnt(64'h0123_4567_89AB_CDEF);
        snap(s); chk("R5 preset copy", s, 64'h0123_4567_89AB_CDEF);
    endtask

    task automatic t_divider;
        logic [63:0] s, s2;
        setcnt(0); run_for(mkctrl(16'd4, 0, 0, 0, 0, 1, 1), 40);
        snap(s); chk("R2 divider 4", s, 10);
        setcnt(0); run_for(mkctrl(16'd1, 0, 0, 0, 0, 1, 1), 20);
        snap(s); chk("R2 divider 1", s, 20);
        setcnt(0); run_for(mkctrl(16'd0, 0, 0, 0, 0, 1, 1), 65540);
        snap(s); chk("R2 divider 0 means 65536", s, 1);
        repeat (50) @(negedge clk);
        snap(s2); chk("R3 paused hold", s2, s);
    endtask

    task automatic t_direction;
        logic [63:0] s;
        setcnt(5); run_for(mkctrl(16'd1, 0, 0, 0, 0, 0, 1), 8);
        snap(s); chk("R4 down wrap", s, 64'hFFFF_FFFF_FFFF_FFFD);
        setcnt(64'hFFFF_FFFF_FFFF_FFFE); run_for(mkctrl(16'd1, 0, 0, 0, 0, 1, 1), 3);
        snap(s); chk("R4 up wrap", s, 64'd1);
    endtask

    task automatic t_snapshot;
        logic [31:0] lo, hi;
        setcnt(64'h0000_0000_FFFF_FFFA);
        wr(W_CTRL, mkctrl(16'd1, 0, 0, 0, 0, 1, 1));
        repeat (9) @(negedge clk);
        wr(W_SGO, 0);
        repeat (5) @(negedge clk);
        rd(W_SLO, lo); rd(W_SHI, hi);
        chk("R6 snapshot low", lo, 32'h3);
        chk("R6 snapshot high", hi, 32'h1);
        wr(W_CTRL, 0);
    endtask

    task automatic t_restart;
        logic [63:0] s;
        logic [31:0] c;
        c = mkctrl(16'd4, 0, 0, 0, 0, 1, 1);
        setcnt(0);
        wr(W_CTRL, c);
        repeat (6) @(negedge clk);
        wr(W_CTRL, c);
        repeat (3) @(negedge clk);
        wr(W_CTRL, 0);
        snap(s); chk("R13 prescaler restart", s, 1);
    endtask

    task automatic t_alarm;
        logic [31:0] v;
        setcnt(0);
        wr(W_CLO, 32'd10); wr(W_CHI, 0); wr(W_MASK, 1);
        edge_cnt = 0;
        wr(W_CTRL, mkctrl(16'd1, 1, 1, 1, 0, 1, 1));
        repeat (30) @(negedge clk);
        rd(W_RAW, v);  chk("R7 raw status set", v, 1);
        rd(W_STAT, v); chk("R10 masked status", v, 1);
        chk("R11 level high", irq_level, 1);
        chk("R12 single edge pulse", edge_cnt, 1);
        rd(W_CTRL, v); chk("R8 arm cleared", v[3], 0);
        wr(W_MASK, 0);
        rd(W_STAT, v); chk("R10 masked off", v, 0);
        rd(W_RAW, v);  chk("R10 raw kept", v, 1);
        chk("R11 level low when masked", irq_level, 0);
        wr(W_MASK, 1);
        wr(W_CLR, 1);
        rd(W_RAW, v);  chk("R10 clear", v, 0);
        chk("R11 level low after clear", irq_level, 0);
        wr(W_CTRL, 0);
        setcnt(0);
        wr(W_CTRL, mkctrl(16'd1, 1, 1, 0, 0, 1, 1));
        repeat (30) @(negedge clk);
        rd(W_RAW, v);  chk("R8 no alarm without rearm", v, 0);
        chk("R8 no edge without rearm", edge_cnt, 1);
        wr(W_CTRL, 0);
        setcnt(0);
        wr(W_CTRL, mkctrl(16'd1, 0, 1, 1, 0, 1, 1));
        repeat (30) @(negedge clk);
        rd(W_RAW, v);  chk("R8 rearmed alarm", v, 1);
        chk("R12 edge disabled", edge_cnt, 1);
        chk("R11 level after rearm", irq_level, 1);
        wr(W_CTRL, 0);
        wr(W_CLR, 1);
    endtask

    task automatic t_autopre;
        logic [31:0] v; logic [63:0] s;
        setcnt(100);
        wr(W_CLO, 32'd105); wr(W_CHI, 0);
        run_for(mkctrl(16'd1, 0, 0, 1, 1, 1, 1), 10);
        snap(s);      chk("R9 auto preset", s, 104);
        rd(W_RAW, v); chk("R9 alarm raised", v, 1);
        chk("R11 level off when disabled", irq_level, 0);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_preset();
        t_divider();
        t_direction();
        t_snapshot();
        t_restart();
        t_alarm();
        t_autopre();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule